// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Emulator

This block is a synthesizable model of a one-time-programmable fuse macro. It lets a fuse sequencer be exercised in simulation with a stand-in that has a realistic pin set. The pins cover word address, bit select, redundancy-set select, serial data-in, write strobe, macro clock, macro enable, program enable, trim enable, a test-mode code and an active-low deep-standby control. Every word is 32 bits wide and is stored twice, once in each of two redundancy cell sets. A cell can only move from 0 to 1, and only a power-on reset clears it.

The emulator runs on a system clock `clk_i`. It samples the macro clock and the write strobe as ordinary inputs and acts on their rising edges. A rising macro-clock edge loads the output register with the addressed word, provided the macro is enabled and awake. The value loaded is the OR of both redundancy copies. A rising write-strobe edge sets one cell, provided every programming condition holds and data-in is 1. Analog timing, repair and test rows or columns are not modelled.

Top module: `otp_fuse_emu`

## Requirements
- R1: After `rst_ni` is asserted, every cell in both sets is 0 and `dout_o` is 0.
- R2: On the first `clk_i` edge that sees `mclk_i` high after it was low, with `ce_i`=1 and `stby_ni`=1, `dout_o` takes the word at `addr_i`. That word is the bitwise OR of its two redundancy copies.
- R3: `dout_o` changes on no other edge. It holds while `mclk_i` is stable, including while `mclk_i` stays high, and while `ce_i`=0.
- R4: A rising edge of `we_i` with programming allowed and `din_i`=1 sets bit `bit_sel_i` (0..31) of word `addr_i` in the set chosen by `red_sel_i` (0 or 1). No other cell changes.
- R5: A write-strobe edge with `din_i`=0 leaves every cell unchanged.
- R6: Programming is allowed only when `ce_i`, `prog_i` and `trim_i` are all 1 and `tmode_i` equals the fuse-program code 2'b10. If any of these fails, write strobes have no effect.
- R7: A set cell never returns to 0 through any input other than `rst_ni`. Programming a set bit again, with either data value, leaves the word unchanged.
- R8: A bit set in only one of the two redundancy copies reads back as 1.
- R9: While `stby_ni`=0 (deep standby), macro-clock edges do not update `dout_o` and write strobes do not program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all macro pins |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| addr_i | input | ADDR_W | Word address for read and program |
| bit_sel_i | input | 5 | Bit position being programmed |
| red_sel_i | input | 1 | Redundancy cell set being programmed |
| din_i | input | 1 | Value of the bit being programmed |
| we_i | input | 1 | Write strobe; rising edge programs |
| mclk_i | input | 1 | Macro clock; rising edge reads |
| ce_i | input | 1 | Macro enable |
| prog_i | input | 1 | Program mode enable |
| trim_i | input | 1 | Trim enable, required for programming |
| tmode_i | input | 2 | Test-mode code; 2'b10 selects fuse programming |
| stby_ni | input | 1 | Deep standby, active low |
| dout_o | output | 32 | Registered read word |

## Verification
The checker watches four things on every cycle. The merged word at a steady address never loses a bit, and it gains at most one bit per edge. Any gain must follow a write-strobe rising edge that had `din_i`=1 and full programming mode. Any change of `dout_o` must follow a macro-clock rising edge seen with the macro enabled and awake. The scenarios cover what a property cannot show on its own. They confirm that the correct cell and set were written, that reads return the OR of the two copies, and that the top address works. They also confirm that each programming condition, removed alone, blocks a write whose effect a later read would have shown.

// File: rtl/otp_emu_pkg.sv
package otp_emu_pkg;
  localparam int WORD_W    = 32;
  localparam int BIT_SEL_W = $clog2(WORD_W);
  localparam int NUM_SETS  = 2;
  localparam int TM_W      = 2;
  localparam logic [TM_W-1:0] TM_FUSE_PROG = 2'b10;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/otp_edge_det.sv
module otp_edge_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sig_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sig_q[g] <= 1'b0;
      else         sig_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~sig_q[g];
  end
endmodule

// File: rtl/otp_cell_bank.sv
module otp_cell_bank
  import otp_emu_pkg::*;
#(
  parameter int NUM_WORDS = 1024,
  parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [ADDR_W-1:0]    set_addr_i,
  input  logic [BIT_SEL_W-1:0] set_bit_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output word_t                rd_word_o
);
  word_t cells [NUM_WORDS];

  // cells only ever set; reset is the sole clearing path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) cells[i] <= '0;
    end else if (set_i) begin
      cells[set_addr_i][set_bit_i] <= 1'b1;
    end
  end

  assign rd_word_o = cells[rd_addr_i];
endmodule

// File: rtl/otp_fuse_emu.sv
module otp_fuse_emu
  import otp_emu_pkg::*;
#(
  parameter int NUM_WORDS = 1024,
  parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [4:0]        bit_sel_i,
  input  logic              red_sel_i,
  input  logic              din_i,
  input  logic              we_i,
  input  logic              mclk_i,
  input  logic              ce_i,
  input  logic              prog_i,
  input  logic              trim_i,
  input  logic [1:0]        tmode_i,
  input  logic              stby_ni,
  output logic [31:0]       dout_o
);
  logic [1:0] rise;
  logic       we_rise, mclk_rise;
  logic       prog_ok, prog_fire, read_fire;
  word_t      set_words [NUM_SETS];
  word_t      merged_word;

  otp_edge_det #(.W(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({we_i, mclk_i}),
    .rise_o (rise)
  );
  assign we_rise   = rise[1];
  assign mclk_rise = rise[0];

  assign prog_ok   = ce_i & prog_i & trim_i & stby_ni & (tmode_i == TM_FUSE_PROG);
  assign prog_fire = prog_ok & we_rise & din_i;
  assign read_fire = ce_i & stby_ni & mclk_rise;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    otp_cell_bank #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (prog_fire && (red_sel_i == 1'(g))),
      .set_addr_i (addr_i),
      .set_bit_i  (bit_sel_i),
      .rd_addr_i  (addr_i),
      .rd_word_o  (set_words[g])
    );
  end

  always_comb begin
    merged_word = '0;
    for (int s = 0; s < NUM_SETS; s++) merged_word |= set_words[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dout_o <= '0;
    else if (read_fire) dout_o <= merged_word;
  end
endmodule

// File: rtl/otp_fuse_emu_chk.sv
module otp_fuse_emu_chk
  import otp_emu_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              din_i,
  input logic              we_i,
  input logic              mclk_i,
  input logic              ce_i,
  input logic              prog_i,
  input logic              trim_i,
  input logic [1:0]        tmode_i,
  input logic              stby_ni,
  input logic [31:0]       merged_word,
  input logic [31:0]       dout_o
);
  AST_CELLS_NEVER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(addr_i) |-> ((merged_word & $past(merged_word)) == $past(merged_word))); // R7

  AST_ONE_BIT_PER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(addr_i) |-> ($countones(merged_word ^ $past(merged_word)) <= 1)); // R4

  AST_PROG_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(addr_i) && (merged_word != $past(merged_word)))
      |-> $past(ce_i && prog_i && trim_i && stby_ni && (tmode_i == TM_FUSE_PROG))); // R6

  AST_PROG_NEEDS_ONE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(addr_i) && (merged_word != $past(merged_word)))
      |-> ($past(din_i) && $past(we_i) && !$past(we_i, 2))); // R5

  AST_DOUT_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_o != $past(dout_o)) |-> ($past(ce_i) && $past(stby_ni))); // R3 R9

  AST_DOUT_NEEDS_MCLK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_o != $past(dout_o)) |-> ($past(mclk_i) && !$past(mclk_i, 2))); // R2
endmodule

bind otp_fuse_emu otp_fuse_emu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .din_i       (din_i),
  .we_i        (we_i),
  .mclk_i      (mclk_i),
  .ce_i        (ce_i),
  .prog_i      (prog_i),
  .trim_i      (trim_i),
  .tmode_i     (tmode_i),
  .stby_ni     (stby_ni),
  .merged_word (merged_word),
  .dout_o      (dout_o)
);

// File: tb/otp_fuse_emu_tb.sv
`timescale 1ns/1ps
module otp_fuse_emu_tb;
  localparam int NUM_WORDS = 1024;
  localparam int ADDR_W    = 10;
  localparam int NVEC      = 8;

  // {addr[48:39], bit[38:34], set[33], din[32], expected read[31:0]}
  localparam logic [48:0] VEC [NVEC] = '{
    {10'd3,    5'd0,  1'b0, 1'b1, 32'h0000_0001},
    {10'd3,    5'd31, 1'b1, 1'b1, 32'h8000_0001},
    {10'd3,    5'd4,  1'b0, 1'b0, 32'h8000_0001},
    {10'd3,    5'd0,  1'b1, 1'b1, 32'h8000_0001},
    {10'd5,    5'd7,  1'b1, 1'b1, 32'h0000_0080},
    {10'd5,    5'd16, 1'b0, 1'b1, 32'h0001_0080},
    {10'd1023, 5'd15, 1'b0, 1'b1, 32'h0000_8000},
    {10'd0,    5'd1,  1'b1, 1'b1, 32'h0000_0002}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [4:0]        bit_sel_i = '0;
  logic              red_sel_i = 1'b0;
  logic              din_i = 1'b0;
  logic              we_i = 1'b0;
  logic              mclk_i = 1'b0;
  logic              ce_i = 1'b0;
  logic              prog_i = 1'b0;
  logic              trim_i = 1'b0;
  logic [1:0]        tmode_i = 2'b00;
  logic              stby_ni = 1'b0;
  logic [31:0]       dout_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  otp_fuse_emu #(.NUM_WORDS(NUM_WORDS)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .bit_sel_i(bit_sel_i),
    .red_sel_i(red_sel_i), .din_i(din_i), .we_i(we_i), .mclk_i(mclk_i),
    .ce_i(ce_i), .prog_i(prog_i), .trim_i(trim_i), .tmode_i(tmode_i),
    .stby_ni(stby_ni), .dout_o(dout_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic mode_all_on();
    ce_i = 1'b1; prog_i = 1'b1; trim_i = 1'b1; tmode_i = 2'b10; stby_ni = 1'b1;
  endtask

  task automatic prog_bit(input logic [ADDR_W-1:0] a, input logic [4:0] b,
                          input logic s, input logic d);
    @(negedge clk_i);
    addr_i = a; bit_sel_i = b; red_sel_i = s; din_i = d;
    @(negedge clk_i); we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic read_word(input logic [ADDR_W-1:0] a);
    @(negedge clk_i); addr_i = a; mclk_i = 1'b1;
    @(negedge clk_i); mclk_i = 1'b0;
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset output", dout_o, 32'h0);
    mode_all_on();
    read_word(10'd3);
    check("R1 cells clear after reset", dout_o, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      prog_bit(VEC[i][48:39], VEC[i][38:34], VEC[i][33], VEC[i][32]);
      read_word(VEC[i][48:39]);
      check($sformatf("R2 R4 R5 R7 R8 vector %0d", i), dout_o, VEC[i][31:0]);
    end

    // R3: address change without a macro-clock edge
    @(negedge clk_i); addr_i = 10'd3;
    repeat (3) @(negedge clk_i);
    check("R3 hold without mclk edge", dout_o, 32'h0000_0002);

    // R3: macro disabled
    ce_i = 1'b0;
    read_word(10'd3);
    check("R3 hold with ce low", dout_o, 32'h0000_0002);
    ce_i = 1'b1;

    // R3: mclk held high acts once
    @(negedge clk_i); addr_i = 10'd5; mclk_i = 1'b1;
    @(negedge clk_i);
    check("R2 read on mclk rise", dout_o, 32'h0001_0080);
    addr_i = 10'd3;
    repeat (2) @(negedge clk_i);
    check("R3 hold while mclk high", dout_o, 32'h0001_0080);
    mclk_i = 1'b0;

    // R9: deep standby blocks reads
    stby_ni = 1'b0;
    read_word(10'd3);
    check("R9 no read in standby", dout_o, 32'h0001_0080);
    stby_ni = 1'b1;

    // R6/R9: each programming condition removed alone
    for (int k = 0; k < 5; k++) begin
      mode_all_on();
      case (k)
        0: ce_i = 1'b0;
        1: prog_i = 1'b0;
        2: trim_i = 1'b0;
        3: tmode_i = 2'b01;
        default: stby_ni = 1'b0;
      endcase
      prog_bit(10'd7, 5'd9, 1'b0, 1'b1);
      mode_all_on();
      read_word(10'd7);
      check((k == 4) ? "R9 no program in standby" : $sformatf("R6 gate %0d blocks program", k),
            dout_o, 32'h0);
    end
    prog_bit(10'd7, 5'd9, 1'b0, 1'b1);
    read_word(10'd7);
    check("R6 program with full mode", dout_o, 32'h0000_0200);

    // R7: zero writes onto set cells in both sets
    prog_bit(10'd3, 5'd31, 1'b0, 1'b0);
    prog_bit(10'd3, 5'd31, 1'b1, 1'b0);
    prog_bit(10'd3, 5'd0,  1'b0, 1'b0);
    read_word(10'd3);
    check("R7 set cells stay set", dout_o, 32'h8000_0001);

    // R2: top address, distinct from previous read
    read_word(10'd1023);
    check("R2 top address read", dout_o, 32'h0000_8000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule